// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Controller

The block moves data between bus addresses without the processor taking part. It has two independent channels. Each request that reaches an enabled channel takes the bus for one transfer: a read of the source address, then a write of the destination address. The unit moved is one byte or one 16-bit word. Between transfers the bus is released, so the processor keeps running.

Each channel holds a source pointer, a destination pointer, a transfer counter with its reload register, a control register and a request selector. At most one pointer counts upward. The upward-counting pointer is run through a separate working pointer, so the programmed value is kept. The counter sets how many units a run moves. When it underflows, the channel raises its interrupt. In single mode the channel then stops. In repeat mode the counter and the working pointer are reloaded and the channel stays enabled.

Registers are reached through a small slave port. Address bit 3 selects the channel and bits 2:0 select the register. Transfers use a request/grant master port.

Top module: `dma_top`

## Requirements
- R1: After reset the master port is idle (`bus_req_o`=0), no interrupt is raised, and every register reads 0.
- R2: The register offsets are 0 source, 1 destination, 2 transfer counter (read-only), 3 reload, 4 control and 5 request select. Control bits are: 0 enable, 1 repeat mode, 2 source forward, 3 destination forward, 4 16-bit unit, 5 software trigger (reads 0).
- R3: Each accepted request produces one read at the source address, then one write at the destination address, carrying the data that was read.
- R4: A 16-bit transfer writes the whole word with `bus_be_o`=11. A byte transfer takes the byte lane given by source address bit 0. It writes that byte to both lanes, with `bus_be_o`=01 for an even destination and 10 for an odd destination.
- R5: When enable goes from 0 to 1, the forward pointer is copied into the working pointer. The working pointer advances by 1 per byte transfer or by 2 per word transfer, and the programmed register keeps its value. If both forward bits are set, the source is forward and the destination is fixed.
- R6: When enable goes from 0 to 1, the counter is loaded from the reload register. It then drops by 1 per transfer, and a transfer made at count 0 underflows it. A reload value N therefore gives N+1 transfers per run.
- R7: In single mode an underflow clears the enable bit, and later requests cause no transfer.
- R8: In repeat mode an underflow reloads the counter and the working pointer, and the enable bit stays set.
- R9: Each underflow raises that channel's `irq_o` bit for exactly one cycle. No other transfer raises it.
- R10: When both channels have a request pending, channel 0 is served first.
- R11: A request is latched only while its channel is enabled, and requests that arrive while one is pending merge into it. Writing enable=0 drops the pending request and withdraws a transfer that is in flight.
- R12: A fixed pointer accepts writes only while its channel is disabled. A forward pointer accepts writes at any time. While the channel is enabled, reading the forward pointer returns the working pointer.
- R13: The request-select register picks which `req_i` bit feeds the channel. Writing the software-trigger bit together with enable=1 makes a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address: bit 3 is the channel, bits 2:0 are the offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| req_i | input | 8 | Request strobes from peripherals |
| bus_req_o | output | 1 | Master bus request |
| bus_gnt_i | input | 1 | Bus grant: the current access completes in this cycle |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 16 | Master address |
| bus_be_o | output | 2 | Byte enables |
| bus_wdata_o | output | 16 | Master write data |
| bus_rdata_i | input | 16 | Read data, valid while granted |
| irq_o | output | 2 | Per-channel underflow interrupt pulse |

## Verification
A request strobe is registered into the pending flag, and one cycle later the engine leaves idle. The read access therefore appears on the master port two cycles after the strobe. The bench does not count that latency itself: it waits for `bus_req_o` and then checks the address, direction, byte enables and data. The write follows in the cycle after the read grant. The interrupt pulse and the counter and pointer updates become visible in the cycle after the write grant, and the bench samples them on the falling edge that follows that grant. Register reads are combinational and are sampled shortly after the address changes. For the cases where nothing should happen, the bench watches `bus_req_o` over a fixed window of cycles.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [2:0] R_SRC = 3'd0;
  localparam logic [2:0] R_DST = 3'd1;
  localparam logic [2:0] R_CNT = 3'd2;
  localparam logic [2:0] R_RLD = 3'd3;
  localparam logic [2:0] R_CTL = 3'd4;
  localparam logic [2:0] R_SEL = 3'd5;

  localparam int unsigned C_EN  = 0;
  localparam int unsigned C_RPT = 1;
  localparam int unsigned C_SFW = 2;
  localparam int unsigned C_DFW = 3;
  localparam int unsigned C_U16 = 4;
  localparam int unsigned C_SWT = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} xfer_st_e;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned CW   = 16,
  parameter int unsigned NREQ = 8,
  localparam int unsigned SW  = $clog2(NREQ)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [NREQ-1:0] req_vec_i,
  input  logic          take_i,
  input  logic          done_i,
  output logic [DW-1:0] src_o,
  output logic [DW-1:0] dst_o,
  output logic          u16_o,
  output logic          en_o,
  output logic          pend_o,
  output logic          irq_o
);
  logic [DW-1:0] src_q, dst_q, wptr_q;
  logic [CW-1:0] cnt_q, rld_q;
  logic [SW-1:0] sel_q;
  logic en_q, rpt_q, sfw_q, dfw_q, u16_q, pend_q, irq_q;
  logic src_fw, dst_fw, wr_ctl, start;

  assign src_fw = sfw_q;
  assign dst_fw = dfw_q & ~sfw_q;  // both forward: destination is fixed
  assign wr_ctl = we_i && addr_i == R_CTL;
  assign start  = wr_ctl && wdata_i[C_EN] && !en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0; dst_q <= '0; wptr_q <= '0; cnt_q <= '0; rld_q <= '0;
      sel_q <= '0; en_q <= 1'b0; rpt_q <= 1'b0; sfw_q <= 1'b0; dfw_q <= 1'b0;
      u16_q <= 1'b0; pend_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (take_i) pend_q <= 1'b0;
      if (en_q && req_vec_i[sel_q]) pend_q <= 1'b1;
      if (done_i) begin
        wptr_q <= wptr_q + (u16_q ? DW'(2) : DW'(1));
        cnt_q  <= cnt_q - CW'(1);
        if (cnt_q == '0) begin
          irq_q <= 1'b1;
          if (rpt_q) begin
            cnt_q  <= rld_q;
            wptr_q <= sfw_q ? src_q : dst_q;
          end else begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
          end
        end
      end
      if (we_i) begin
        unique case (addr_i)
          R_SRC: if (src_fw || !en_q) src_q <= wdata_i;
          R_DST: if (dst_fw || !en_q) dst_q <= wdata_i;
          R_RLD: rld_q <= wdata_i[CW-1:0];
          R_CTL: begin
            en_q  <= wdata_i[C_EN];
            rpt_q <= wdata_i[C_RPT];
            sfw_q <= wdata_i[C_SFW];
            dfw_q <= wdata_i[C_DFW];
            u16_q <= wdata_i[C_U16];
            if (start) begin
              cnt_q  <= rld_q;
              wptr_q <= wdata_i[C_SFW] ? src_q : dst_q;
            end
            if (!wdata_i[C_EN]) pend_q <= 1'b0;
            else if (wdata_i[C_SWT]) pend_q <= 1'b1;
          end
          R_SEL: sel_q <= wdata_i[SW-1:0];
          default: ;
        endcase
      end
    end
  end

  assign src_o  = src_fw ? wptr_q : src_q;
  assign dst_o  = dst_fw ? wptr_q : dst_q;
  assign u16_o  = u16_q;
  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      R_SRC: rdata_o = (src_fw && en_q) ? wptr_q : src_q;
      R_DST: rdata_o = (dst_fw && en_q) ? wptr_q : dst_q;
      R_CNT: rdata_o = DW'(cnt_q);
      R_RLD: rdata_o = DW'(rld_q);
      R_CTL: rdata_o = DW'({u16_q, dfw_q, sfw_q, rpt_q, en_q});
      R_SEL: rdata_o = DW'(sel_q);
      default: rdata_o = '0;
    endcase
  end

  // R6
  a_r6_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && cnt_q != '0 && !wr_ctl |=> cnt_q == $past(cnt_q) - CW'(1));
  a_r7_single_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && cnt_q == '0 && !rpt_q && !wr_ctl |=> !en_q);
  a_r8_repeat_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && cnt_q == '0 && rpt_q && !wr_ctl |=> en_q && cnt_q == $past(rld_q));
  a_r9_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r12_fixed_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && we_i && addr_i == R_SRC && !sfw_q |=> $stable(src_q));
endmodule

// File: rtl/dma_eng.sv
module dma_eng
  import dma_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned NCH = 2,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned BEW = DW / 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NCH-1:0]          pend_i,
  input  logic [NCH-1:0]          en_i,
  input  logic [NCH-1:0]          u16_i,
  input  logic [NCH-1:0][DW-1:0]  src_i,
  input  logic [NCH-1:0][DW-1:0]  dst_i,
  output logic [NCH-1:0]          take_o,
  output logic [NCH-1:0]          done_o,
  output logic                    bus_req_o,
  input  logic                    bus_gnt_i,
  output logic                    bus_we_o,
  output logic [DW-1:0]           bus_addr_o,
  output logic [BEW-1:0]          bus_be_o,
  output logic [DW-1:0]           bus_wdata_o,
  input  logic [DW-1:0]           bus_rdata_i
);
  xfer_st_e state_q;
  logic [CHW-1:0] act_q, pick;
  logic found, act_en, lane_q;
  logic [DW-1:0] data_q, addr;
  logic [7:0] byte_v;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        found = 1'b1;
        pick  = CHW'(i);
      end
    end
  end

  assign act_en = en_i[act_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
      data_q  <= '0;
      lane_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (found) begin
          state_q <= ST_RD;
          act_q   <= pick;
        end
        ST_RD: begin
          if (!act_en) state_q <= ST_IDLE;
          else if (bus_gnt_i) begin
            data_q  <= bus_rdata_i;
            lane_q  <= addr[0];
            state_q <= ST_WR;
          end
        end
        ST_WR: if (!act_en || bus_gnt_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    take_o = '0;
    done_o = '0;
    if (state_q == ST_IDLE && found) take_o[pick] = 1'b1;
    if (state_q == ST_WR && act_en && bus_gnt_i) done_o[act_q] = 1'b1;
  end

  assign addr        = (state_q == ST_WR) ? dst_i[act_q] : src_i[act_q];
  assign byte_v      = lane_q ? data_q[15:8] : data_q[7:0];
  assign bus_req_o   = (state_q != ST_IDLE) && act_en;
  assign bus_we_o    = (state_q == ST_WR);
  assign bus_addr_o  = addr;
  assign bus_be_o    = u16_i[act_q] ? '1 : (addr[0] ? BEW'(2) : BEW'(1));
  assign bus_wdata_o = u16_i[act_q] ? data_q : {BEW{byte_v}};

  a_r10_ch0_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE && pend_i[0] |=> state_q == ST_RD && act_q == '0);
  a_r3_wr_after_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_we_o && bus_gnt_i |=> state_q == ST_WR);
  a_r3_idle_after_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o && bus_gnt_i |=> !bus_req_o);
endmodule

// File: rtl/dma_top.sv
module dma_top
  import dma_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned CW   = 16,
  parameter int unsigned NCH  = 2,
  parameter int unsigned NREQ = 8,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned RAW = 3 + CHW,
  localparam int unsigned BEW = DW / 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [RAW-1:0]  reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  input  logic [NREQ-1:0] req_i,
  output logic            bus_req_o,
  input  logic            bus_gnt_i,
  output logic            bus_we_o,
  output logic [DW-1:0]   bus_addr_o,
  output logic [BEW-1:0]  bus_be_o,
  output logic [DW-1:0]   bus_wdata_o,
  input  logic [DW-1:0]   bus_rdata_i,
  output logic [NCH-1:0]  irq_o
);
  logic [NCH-1:0] pend, en, u16, take, done;
  logic [NCH-1:0][DW-1:0] src, dst, rdat;
  logic [CHW-1:0] csel;

  assign csel = reg_addr_i[RAW-1:3];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_chan #(.DW(DW), .CW(CW), .NREQ(NREQ)) u_ch (
      .clk_i, .rst_ni,
      .we_i      (reg_we_i && csel == CHW'(c)),
      .addr_i    (reg_addr_i[2:0]),
      .wdata_i   (reg_wdata_i),
      .rdata_o   (rdat[c]),
      .req_vec_i (req_i),
      .take_i    (take[c]),
      .done_i    (done[c]),
      .src_o     (src[c]),
      .dst_o     (dst[c]),
      .u16_o     (u16[c]),
      .en_o      (en[c]),
      .pend_o    (pend[c]),
      .irq_o     (irq_o[c])
    );
  end

  assign reg_rdata_o = rdat[csel];

  dma_eng #(.DW(DW), .NCH(NCH)) u_eng (
    .clk_i, .rst_ni,
    .pend_i (pend), .en_i (en), .u16_i (u16), .src_i (src), .dst_i (dst),
    .take_o (take), .done_o (done),
    .bus_req_o, .bus_gnt_i, .bus_we_o, .bus_addr_o, .bus_be_o,
    .bus_wdata_o, .bus_rdata_i
  );
endmodule

// File: tb/tb_dma_top.sv
module tb_dma_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [7:0] req = '0;
  logic bus_req, bus_gnt = 1'b0, bus_we;
  logic [15:0] bus_addr, bus_wdata, bus_rdata = '0;
  logic [1:0] bus_be, irq;

  int checks = 0, errors = 0;
  bit fin = 1'b0;
  logic last_irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_top dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .req_i(req),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_we_o(bus_we),
    .bus_addr_o(bus_addr), .bus_be_o(bus_be), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .irq_o(irq)
  );

  function automatic logic [15:0] mem(input logic [15:0] a);
    return a * 16'd3 + 16'h1111;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int c, input int r, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(c * 8 + r); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int c, input int r, output logic [15:0] v);
    @(negedge clk);
    reg_addr = 4'(c * 8 + r);
    #1 v = reg_rdata;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    req[idx] = 1'b1;
    @(negedge clk);
    req[idx] = 1'b0;
  endtask

  task automatic bus_op(input bit we, input logic [15:0] a, input logic [1:0] be,
                        input logic [15:0] wd, input string tag);
    int n = 0;
    while (!bus_req && n < 30) begin @(negedge clk); n++; end
    chk(bus_req == 1'b1, {tag, " req"}, int'(bus_req), 1);
    chk(bus_we == we, {tag, " dir"}, int'(bus_we), int'(we));
    chk(bus_addr == a, {tag, " addr"}, int'(bus_addr), int'(a));
    if (we) begin
      chk(bus_be == be, {tag, " be"}, int'(bus_be), int'(be));
      chk(bus_wdata == wd, {tag, " data"}, int'(bus_wdata), int'(wd));
    end
    repeat ($urandom_range(0, 2)) @(negedge clk);
    bus_gnt = 1'b1; bus_rdata = mem(a);
    @(negedge clk);
    bus_gnt = 1'b0;
    last_irq = |irq;
  endtask

  task automatic xfer(input logic [15:0] sa, input logic [15:0] da, input bit u16,
                      input string tag);
    logic [15:0] r = mem(sa);
    logic [7:0] b = sa[0] ? r[15:8] : r[7:0];
    bus_op(1'b0, sa, 2'b00, 16'h0, tag);
    bus_op(1'b1, da, u16 ? 2'b11 : (da[0] ? 2'b10 : 2'b01), u16 ? r : {b, b}, tag);
  endtask

  task automatic no_xfer(input int n, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin @(negedge clk); seen |= bus_req; end
    chk(!seen, tag, int'(seen), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(bus_req == 1'b0 && irq == 2'b00, "R1 idle", int'({bus_req, irq}), 0);
    rd(0, 4, v); chk(v == 0, "R1 ctrl0", v, 0);
    rd(1, 2, v); chk(v == 0, "R1 cnt1", v, 0);

    // R2 R3 R5 R6 R7 R9: single mode byte, source forward
    wr(0, 0, 16'h1001); wr(0, 1, 16'h2000); wr(0, 3, 2); wr(0, 5, 3);
    wr(0, 4, 16'h05);
    rd(0, 2, v); chk(v == 2, "R6 counter loaded", v, 2);
    rd(0, 3, v); chk(v == 2, "R2 reload readback", v, 2);
    pulse(3); xfer(16'h1001, 16'h2000, 0, "R3 first");
    chk(last_irq == 0, "R9 no irq", last_irq, 0);
    rd(0, 0, v); chk(v == 16'h1002, "R12 working ptr read", v, 16'h1002);
    rd(0, 2, v); chk(v == 1, "R6 count down", v, 1);
    pulse(3); xfer(16'h1002, 16'h2000, 0, "R5 advance");
    pulse(3); xfer(16'h1003, 16'h2000, 0, "R4 odd lane");
    chk(last_irq == 1, "R9 irq on underflow", last_irq, 1);
    @(negedge clk); chk(irq == 0, "R9 one cycle", int'(irq), 0);
    rd(0, 4, v); chk(v[0] == 0, "R7 enable cleared", v, 0);
    rd(0, 0, v); chk(v == 16'h1001, "R5 register kept", v, 16'h1001);
    pulse(3); no_xfer(10, "R7 no transfer after stop");

    // R11 R13: request while disabled ignored, selector
    wr(1, 5, 5); pulse(5);
    wr(1, 0, 16'h3000); wr(1, 1, 16'h4000); wr(1, 3, 1);
    wr(1, 4, 16'h19);
    no_xfer(10, "R11 early request dropped");
    pulse(4); no_xfer(8, "R13 other source ignored");

    // R12 R4: lock rules, word transfer, destination forward
    wr(1, 0, 16'h3333); rd(1, 0, v); chk(v == 16'h3000, "R12 fixed locked", v, 16'h3000);
    wr(1, 1, 16'h5000); rd(1, 1, v); chk(v == 16'h4000, "R12 fwd reads working", v, 16'h4000);
    pulse(5); xfer(16'h3000, 16'h4000, 1, "R4 word");
    pulse(5); xfer(16'h3000, 16'h4002, 1, "R5 step 2");
    chk(last_irq == 1, "R9 irq ch1", last_irq, 1);
    rd(1, 1, v); chk(v == 16'h5000, "R12 fwd write accepted", v, 16'h5000);

    // R10 priority, R4 high lane write
    wr(0, 0, 16'h10); wr(0, 1, 16'h30); wr(0, 3, 0); wr(0, 5, 2); wr(0, 4, 16'h05);
    wr(1, 0, 16'h20); wr(1, 1, 16'h41); wr(1, 3, 0); wr(1, 5, 2); wr(1, 4, 16'h05);
    pulse(2);
    xfer(16'h10, 16'h30, 0, "R10 ch0 first");
    xfer(16'h20, 16'h41, 0, "R10 ch1 second");

    // R5 both forward: destination fixed
    wr(0, 0, 16'h50); wr(0, 1, 16'h60); wr(0, 3, 1); wr(0, 4, 16'h0D);
    pulse(2); xfer(16'h50, 16'h60, 0, "R5 both fwd a");
    pulse(2); xfer(16'h51, 16'h60, 0, "R5 both fwd b");

    // R8 R13: repeat mode by software trigger
    wr(1, 0, 16'h70); wr(1, 1, 16'h80); wr(1, 3, 1); wr(1, 4, 16'h27);
    xfer(16'h70, 16'h80, 0, "R13 sw trigger");
    wr(1, 4, 16'h27); xfer(16'h71, 16'h80, 0, "R8 second");
    chk(last_irq == 1, "R8 irq", last_irq, 1);
    rd(1, 4, v); chk(v[0] == 1, "R8 still enabled", v, 1);
    rd(1, 2, v); chk(v == 1, "R8 counter reloaded", v, 1);
    wr(1, 4, 16'h27); xfer(16'h70, 16'h80, 0, "R8 pointer reloaded");
    wr(1, 4, 0); wr(1, 4, 16'h20); no_xfer(10, "R11 trigger while disabled");

    // R11 abort in flight
    wr(0, 0, 16'h90); wr(0, 3, 5); wr(0, 4, 16'h05); pulse(2);
    while (!bus_req) @(negedge clk);
    wr(0, 4, 0);
    chk(bus_req == 0, "R11 abort", int'(bus_req), 0);
    no_xfer(8, "R11 nothing after abort");

    // random configurations
    for (int it = 0; it < 14; it++) begin
      int c, dir, rl, sl, nt, k, step;
      bit u, rp;
      logic [15:0] sa, da, esa, eda;
      c = $urandom_range(0, 1); u = 1'($urandom_range(0, 1)); dir = $urandom_range(0, 2);
      rp = 1'($urandom_range(0, 1)); rl = $urandom_range(0, 3); sl = $urandom_range(0, 7);
      sa = 16'($urandom); da = 16'($urandom); step = u ? 2 : 1;
      wr(c, 0, sa); wr(c, 1, da); wr(c, 3, rl); wr(c, 5, sl);
      wr(c, 4, 1 | (int'(rp) << 1) | (int'(dir == 0) << 2) | (int'(dir == 1) << 3) | (int'(u) << 4));
      nt = rp ? rl + 2 : rl + 1; k = 0;
      for (int t = 0; t < nt; t++) begin
        esa = (dir == 0) ? sa + 16'(k * step) : sa;
        eda = (dir == 1) ? da + 16'(k * step) : da;
        pulse(sl); xfer(esa, eda, u, "R3 random");
        chk(last_irq == (k == rl), "R9 random irq", last_irq, int'(k == rl));
        k = (k == rl) ? 0 : k + 1;
      end
      rd(c, 4, v); chk(v[0] == rp, "R7 R8 random enable", v[0], rp);
      wr(c, 4, 0);
    end

    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule